// File: doc/BRIEF.md
# Indexed display-control register file

This block gives a host a two-port window onto a display controller's control registers. The host writes a register number to the index port (port 0). It then reads or writes the selected register through the value port (port 1). The register space holds several kinds of entries:

- read-only entries: identity, maximum geometry, pixel-format masks and capabilities;
- mode entries: enable, width, height and depth;
- cursor entries: identifier, position and visibility;
- a bank of general-purpose scratch words placed at a fixed index.

Writes to the configuration-done and synchronise entries also emit single-cycle strobes. These strobes drive command-ring logic that sits outside this block.

The pixel depth is supplied by the display side on `host_depth_i`. The block derives several values from that depth rounded up to whole bytes: the reported bits per pixel, the line pitch and the frame size. The frame size is captured when the display is enabled. The index numbers listed below are fixed, because driver software decodes them.

Top module: `idx_reg_file`

## Requirements
- R1: Index 0 reads `{24'h900000, version}` and resets to version 2. A value-port write to index 0 is stored only when bits 31:8 equal 24'h900000 and bits 7:0 are 0, 1 or 2. Any other value leaves index 0 unchanged.
- R2: Index 4 reads the maximum width (2360). Index 5 reads the maximum height (1770).
- R3: Index 7 (bits per pixel) and index 28 (host bits per pixel) both read the depth rounded up to a multiple of 8.
- R4: Index 12 reads the line pitch, `((depth+7)>>3) * width`, where width is the value last written to index 2.
- R5: Writing a nonzero value to index 1 sets `enable_o`. It also latches `fb_size_o = ((depth+7)>>3) * width * height`, which index 16 then reads. Writing 0 to index 1 clears both `enable_o` and `config_done_o`. Later writes to width or height do not change the latched frame size.
- R6: A write to index 7 has no effect. The value read back from index 7 is unchanged afterwards.
- R7: Index 27 controls cursor visibility. Writing 1 sets `cursor_on_o` and writing 0 clears it. Writing 2, 3 or any larger value leaves it unchanged.
- R8: Scratch words occupy indices 1792 to 1792+SCR_N-1 and are readable and writable. Index 29 reads SCR_N. Index 1792+SCR_N is outside the bank: it reads 0 and a write to it stores nothing.
- R9: The colour masks at indices 9, 10 and 11 (red, green, blue) depend on depth:
  - depth 16: 0x1f, 0x7e0, 0xf800;
  - depth 15: 0x1f, 0x3e0, 0x7c00;
  - any other depth: 0xff0000, 0xff00, 0xff.
- R10: Any index not listed above reads 0, and a write to such an index changes no register or output.
- R11: A write to index 20 sets `config_done_o` to the nonzero-ness of the written value and pulses `cfg_stb_o` for one cycle. A write to index 21 pulses `sync_stb_o` for one cycle. Both strobes appear in the cycle after the write.
- R12: When a read and a write of the value port fall in the same cycle, the read returns the register's value from before the write.
- R13: Read data appears on `bus_rdata_o`, with `bus_rvalid_o` high, exactly one cycle after `bus_rd_i`. A read of port 0 returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_port_i | input | 1 | 0 selects the index port, 1 selects the value port |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| host_depth_i | input | 6 | Current pixel depth in bits |
| enable_o | output | 1 | Display enabled |
| config_done_o | output | 1 | Command area configured |
| cfg_stb_o | output | 1 | Pulse after a configuration-done write |
| sync_stb_o | output | 1 | Pulse after a synchronise write |
| width_o | output | DIM_W | Pending width |
| height_o | output | DIM_W | Pending height |
| fb_size_o | output | 4+2*DIM_W | Frame size latched at enable |
| cursor_id_o | output | 32 | Cursor identifier |
| cursor_x_o | output | POS_W | Cursor X |
| cursor_y_o | output | POS_W | Cursor Y |
| cursor_on_o | output | 1 | Cursor visible |

## Verification
A value-port read and a value-port write can land in the same cycle. The bench provokes this by raising both strobes while the cursor X entry is selected. It expects the read to return the earlier X value, and a follow-up read to return the newly written one. The second overlap is a disable write issued while configuration-done is set. Here the bench checks that one write drops both `enable_o` and `config_done_o` together.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;
  localparam int unsigned IX_ID       = 0;
  localparam int unsigned IX_EN       = 1;
  localparam int unsigned IX_WID      = 2;
  localparam int unsigned IX_HGT      = 3;
  localparam int unsigned IX_MAXW     = 4;
  localparam int unsigned IX_MAXH     = 5;
  localparam int unsigned IX_BPP      = 7;
  localparam int unsigned IX_RMASK    = 9;
  localparam int unsigned IX_GMASK    = 10;
  localparam int unsigned IX_BMASK    = 11;
  localparam int unsigned IX_PITCH    = 12;
  localparam int unsigned IX_FBSZ     = 16;
  localparam int unsigned IX_CAPS     = 17;
  localparam int unsigned IX_CFG      = 20;
  localparam int unsigned IX_SYNC     = 21;
  localparam int unsigned IX_CUR_ID   = 24;
  localparam int unsigned IX_CUR_X    = 25;
  localparam int unsigned IX_CUR_Y    = 26;
  localparam int unsigned IX_CUR_ON   = 27;
  localparam int unsigned IX_HBPP     = 28;
  localparam int unsigned IX_SCR_N    = 29;
  localparam int unsigned IX_SCR_BASE = 1792;

  localparam logic [23:0] ID_MAGIC = 24'h900000;
  localparam logic [7:0]  ID_VMAX  = 8'd2;

  typedef struct packed {
    logic [31:0] r;
    logic [31:0] g;
    logic [31:0] b;
  } mask_t;

  function automatic logic [3:0] bytes_pp(input logic [5:0] d);
    logic [6:0] s;
    s = {1'b0, d} + 7'd7;
    return s[6:3];
  endfunction

  function automatic logic [31:0] round_bpp(input logic [5:0] d);
    return {25'd0, bytes_pp(d), 3'b000};
  endfunction

  function automatic mask_t col_masks(input logic [5:0] d);
    mask_t m;
    if (d == 6'd16)      m = '{r: 32'h1f,     g: 32'h7e0,  b: 32'hf800};
    else if (d == 6'd15) m = '{r: 32'h1f,     g: 32'h3e0,  b: 32'h7c00};
    else                 m = '{r: 32'hff0000, g: 32'hff00, b: 32'hff};
    return m;
  endfunction
endpackage

// File: rtl/ixreg_mode.sv
module ixreg_mode
  import ixreg_pkg::*;
#(
  parameter int unsigned DIM_W = 12,
  localparam int unsigned FB_W = 4 + 2 * DIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      idx_i,
  input  logic [31:0]      wdata_i,
  input  logic [5:0]       depth_i,
  output logic [31:0]      id_o,
  output logic             enable_o,
  output logic             cfg_done_o,
  output logic             cfg_stb_o,
  output logic             sync_stb_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic [FB_W-1:0]  fb_size_o
);
  logic            id_ok;
  logic            nz;
  logic [FB_W-1:0] fb_calc;

  assign id_ok   = (wdata_i[31:8] == ID_MAGIC) && (wdata_i[7:0] <= ID_VMAX);
  assign nz      = |wdata_i;
  assign fb_calc = FB_W'(bytes_pp(depth_i)) * FB_W'(width_o) * FB_W'(height_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o       <= {ID_MAGIC, ID_VMAX};
      enable_o   <= 1'b0;
      cfg_done_o <= 1'b0;
      cfg_stb_o  <= 1'b0;
      sync_stb_o <= 1'b0;
      width_o    <= '0;
      height_o   <= '0;
      fb_size_o  <= '0;
    end else begin
      cfg_stb_o  <= wr_i && (idx_i == IX_CFG);
      sync_stb_o <= wr_i && (idx_i == IX_SYNC);
      if (wr_i) begin
        if (idx_i == IX_ID && id_ok) id_o <= wdata_i;
        if (idx_i == IX_EN) begin
          enable_o <= nz;
          if (nz) fb_size_o  <= fb_calc;
          else    cfg_done_o <= 1'b0;
        end
        if (idx_i == IX_WID) width_o    <= wdata_i[DIM_W-1:0];
        if (idx_i == IX_HGT) height_o   <= wdata_i[DIM_W-1:0];
        if (idx_i == IX_CFG) cfg_done_o <= nz;
      end
    end
  end
endmodule

// File: rtl/ixreg_cursor.sv
module ixreg_cursor
  import ixreg_pkg::*;
#(
  parameter int unsigned POS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      cur_id_o,
  output logic [POS_W-1:0] cur_x_o,
  output logic [POS_W-1:0] cur_y_o,
  output logic             cur_on_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_id_o <= '0;
      cur_x_o  <= '0;
      cur_y_o  <= '0;
      cur_on_o <= 1'b0;
    end else if (wr_i) begin
      if (idx_i == IX_CUR_ID) cur_id_o <= wdata_i;
      if (idx_i == IX_CUR_X)  cur_x_o  <= wdata_i[POS_W-1:0];
      if (idx_i == IX_CUR_Y)  cur_y_o  <= wdata_i[POS_W-1:0];
      if (idx_i == IX_CUR_ON) begin
        // codes above 1 keep visibility
        if (wdata_i == 32'd1)      cur_on_o <= 1'b1;
        else if (wdata_i == 32'd0) cur_on_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ixreg_scratch.sv
module ixreg_scratch
  import ixreg_pkg::*;
#(
  parameter int unsigned SCR_N = 16,
  localparam int unsigned AW   = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] idx_i,
  input  logic [31:0] wdata_i,
  output logic        hit_o,
  output logic [31:0] rdata_o
);
  logic [31:0] mem_q [SCR_N];
  logic [31:0] off;
  logic [AW-1:0] sel;

  assign off     = idx_i - IX_SCR_BASE;
  assign hit_o   = (idx_i >= IX_SCR_BASE) && (off < SCR_N);
  assign sel     = off[AW-1:0];
  assign rdata_o = hit_o ? mem_q[sel] : 32'd0;

  for (genvar i = 0; i < SCR_N; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (wr_i && hit_o && sel == AW'(i)) mem_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/idx_reg_file.sv
module idx_reg_file
  import ixreg_pkg::*;
#(
  parameter int unsigned DIM_W = 12,
  parameter int unsigned POS_W = 32,
  parameter int unsigned IDX_W = 16,
  parameter int unsigned SCR_N = 16,
  parameter int unsigned MAX_W = 2360,
  parameter int unsigned MAX_H = 1770,
  parameter logic [31:0] CAPS  = 32'h0000_00e3,
  localparam int unsigned FB_W = 4 + 2 * DIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic             bus_port_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             bus_rvalid_o,
  input  logic [5:0]       host_depth_i,
  output logic             enable_o,
  output logic             config_done_o,
  output logic             cfg_stb_o,
  output logic             sync_stb_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic [FB_W-1:0]  fb_size_o,
  output logic [31:0]      cursor_id_o,
  output logic [POS_W-1:0] cursor_x_o,
  output logic [POS_W-1:0] cursor_y_o,
  output logic             cursor_on_o
);
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      idx_ext;
  logic             val_wr;
  logic [31:0]      id_val;
  logic             scr_hit;
  logic [31:0]      scr_rdata;
  logic [31:0]      rd_val;
  mask_t            masks;

  assign idx_ext = 32'(idx_q);
  assign val_wr  = bus_wr_i && bus_port_i;
  assign masks   = col_masks(host_depth_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (bus_wr_i && !bus_port_i) idx_q <= bus_wdata_i[IDX_W-1:0];
  end

  ixreg_mode #(.DIM_W(DIM_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (val_wr),
    .idx_i      (idx_ext),
    .wdata_i    (bus_wdata_i),
    .depth_i    (host_depth_i),
    .id_o       (id_val),
    .enable_o   (enable_o),
    .cfg_done_o (config_done_o),
    .cfg_stb_o  (cfg_stb_o),
    .sync_stb_o (sync_stb_o),
    .width_o    (width_o),
    .height_o   (height_o),
    .fb_size_o  (fb_size_o)
  );

  ixreg_cursor #(.POS_W(POS_W)) u_cursor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (val_wr),
    .idx_i    (idx_ext),
    .wdata_i  (bus_wdata_i),
    .cur_id_o (cursor_id_o),
    .cur_x_o  (cursor_x_o),
    .cur_y_o  (cursor_y_o),
    .cur_on_o (cursor_on_o)
  );

  ixreg_scratch #(.SCR_N(SCR_N)) u_scratch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (val_wr),
    .idx_i   (idx_ext),
    .wdata_i (bus_wdata_i),
    .hit_o   (scr_hit),
    .rdata_o (scr_rdata)
  );

  always_comb begin
    rd_val = '0;
    if (scr_hit) rd_val = scr_rdata;
    else begin
      case (idx_ext)
        IX_ID:             rd_val = id_val;
        IX_EN:             rd_val = {31'd0, enable_o};
        IX_WID:            rd_val = 32'(width_o);
        IX_HGT:            rd_val = 32'(height_o);
        IX_MAXW:           rd_val = MAX_W;
        IX_MAXH:           rd_val = MAX_H;
        IX_BPP, IX_HBPP:   rd_val = round_bpp(host_depth_i);
        IX_RMASK:          rd_val = masks.r;
        IX_GMASK:          rd_val = masks.g;
        IX_BMASK:          rd_val = masks.b;
        IX_PITCH:          rd_val = 32'(bytes_pp(host_depth_i)) * 32'(width_o);
        IX_FBSZ:           rd_val = 32'(fb_size_o);
        IX_CAPS:           rd_val = CAPS;
        IX_CFG:            rd_val = {31'd0, config_done_o};
        IX_CUR_ID:         rd_val = cursor_id_o;
        IX_CUR_X:          rd_val = 32'(cursor_x_o);
        IX_CUR_Y:          rd_val = 32'(cursor_y_o);
        IX_CUR_ON:         rd_val = {31'd0, cursor_on_o};
        IX_SCR_N:          rd_val = SCR_N;
        default:           rd_val = '0;
      endcase
    end
  end

  // read samples pre-write state: same-cycle write lands at this edge too
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_rd_i;
      if (bus_rd_i) bus_rdata_o <= bus_port_i ? rd_val : idx_ext;
    end
  end
endmodule

// File: rtl/ixreg_chk.sv
module ixreg_chk
  import ixreg_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic        bus_port_i,
  input logic [31:0] bus_wdata_i,
  input logic [31:0] bus_rdata_o,
  input logic        bus_rvalid_o,
  input logic        config_done_o,
  input logic        cursor_on_o,
  input logic        cfg_stb_o,
  input logic        sync_stb_o,
  input logic [31:0] idx_i
);
  a_r1_id_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_port_i && idx_i == IX_ID) |=>
      (bus_rdata_o[31:8] == ID_MAGIC && bus_rdata_o[7:0] <= ID_VMAX));

  a_r5_disable_drops_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_port_i && idx_i == IX_EN && bus_wdata_i == 32'd0) |=> !config_done_o);

  a_r7_cursor_codes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_port_i && idx_i == IX_CUR_ON && bus_wdata_i > 32'd1) |=> $stable(cursor_on_o));

  a_r11_sync_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_stb_o |-> $past(bus_wr_i && bus_port_i && idx_i == IX_SYNC));

  a_r11_cfg_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_stb_o |-> $past(bus_wr_i && bus_port_i && idx_i == IX_CFG));

  a_r13_rvalid_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o == $past(bus_rd_i));
endmodule

bind idx_reg_file ixreg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_wr_i      (bus_wr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_port_i    (bus_port_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .bus_rvalid_o  (bus_rvalid_o),
  .config_done_o (config_done_o),
  .cursor_on_o   (cursor_on_o),
  .cfg_stb_o     (cfg_stb_o),
  .sync_stb_o    (sync_stb_o),
  .idx_i         (idx_ext)
);

// File: tb/idx_reg_file_tb.sv
`timescale 1ns/1ps
module idx_reg_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_port = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [5:0]  host_depth = 6'd32;
  logic        enable, cfg_done, cfg_stb, sync_stb, cur_on;
  logic [11:0] width, height;
  logic [27:0] fb_size;
  logic [31:0] cur_id, cur_x, cur_y;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  idx_reg_file u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_port_i(bus_port),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .host_depth_i(host_depth),
    .enable_o(enable), .config_done_o(cfg_done), .cfg_stb_o(cfg_stb), .sync_stb_o(sync_stb),
    .width_o(width), .height_o(height), .fb_size_o(fb_size),
    .cursor_id_o(cur_id), .cursor_x_o(cur_x), .cursor_y_o(cur_y), .cursor_on_o(cur_on)
  );

  function automatic void chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb_q.size() == 0) chk(32'hdead_beef, 32'h0, "R13 unexpected rvalid");
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(bus_rdata, e.exp, e.tag);
      end
    end
  end

  task automatic bus_cycle(input logic wr, input logic rd, input logic port, input logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_port = port; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input int unsigned idx, input logic [31:0] v);
    bus_cycle(1'b1, 1'b0, 1'b0, idx);
    bus_cycle(1'b1, 1'b0, 1'b1, v);
  endtask

  task automatic rd_reg(input int unsigned idx, input logic [31:0] exp, input string tag);
    exp_t e;
    bus_cycle(1'b1, 1'b0, 1'b0, idx);
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    bus_cycle(1'b0, 1'b1, 1'b1, 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'd0, enable}, 32'd0, "R5 reset enable");
    chk({31'd0, cfg_done}, 32'd0, "R11 reset config_done");
    chk({31'd0, cur_on}, 32'd0, "R7 reset cursor_on");
    rd_reg(0, 32'h9000_0002, "R1 reset id");

    wr_reg(0, 32'h9000_0001);
    rd_reg(0, 32'h9000_0001, "R1 id v1");
    wr_reg(0, 32'h9000_0003);
    rd_reg(0, 32'h9000_0001, "R1 id v3 rejected");
    wr_reg(0, 32'h1234_5600);
    rd_reg(0, 32'h9000_0001, "R1 id bad magic rejected");
    wr_reg(0, 32'h9000_0000);
    rd_reg(0, 32'h9000_0000, "R1 id v0");

    rd_reg(4, 32'd2360, "R2 max width");
    rd_reg(5, 32'd1770, "R2 max height");

    host_depth = 6'd15;
    rd_reg(7, 32'd16, "R3 bpp d15");
    rd_reg(28, 32'd16, "R3 host bpp d15");
    rd_reg(9, 32'h1f, "R9 red d15");
    rd_reg(10, 32'h3e0, "R9 green d15");
    rd_reg(11, 32'h7c00, "R9 blue d15");
    wr_reg(2, 32'd640);
    rd_reg(12, 32'd1280, "R4 pitch d15");
    host_depth = 6'd16;
    rd_reg(9, 32'h1f, "R9 red d16");
    rd_reg(10, 32'h7e0, "R9 green d16");
    rd_reg(11, 32'hf800, "R9 blue d16");
    host_depth = 6'd24;
    rd_reg(7, 32'd24, "R3 bpp d24");
    wr_reg(2, 32'd100);
    rd_reg(12, 32'd300, "R4 pitch d24");
    rd_reg(9, 32'hff0000, "R9 red d24");
    rd_reg(11, 32'hff, "R9 blue d24");
    host_depth = 6'd32;
    rd_reg(10, 32'hff00, "R9 green d32");

    wr_reg(7, 32'd16);
    rd_reg(7, 32'd32, "R6 bpp write ignored");

    wr_reg(2, 32'd640);
    wr_reg(3, 32'd480);
    wr_reg(1, 32'd1);
    chk({31'd0, enable}, 32'd1, "R5 enable set");
    chk(32'(fb_size), 32'd1228800, "R5 fb size latched");
    rd_reg(16, 32'd1228800, "R5 fb size reg");
    wr_reg(2, 32'd800);
    chk(32'(fb_size), 32'd1228800, "R5 fb size held after width write");

    bus_cycle(1'b1, 1'b0, 1'b0, 32'd20);
    bus_cycle(1'b1, 1'b0, 1'b1, 32'd1);
    chk({31'd0, cfg_stb}, 32'd1, "R11 cfg strobe");
    chk({31'd0, cfg_done}, 32'd1, "R11 config_done set");
    @(negedge clk);
    chk({31'd0, cfg_stb}, 32'd0, "R11 cfg strobe one cycle");
    bus_cycle(1'b1, 1'b0, 1'b0, 32'd21);
    bus_cycle(1'b1, 1'b0, 1'b1, 32'd7);
    chk({31'd0, sync_stb}, 32'd1, "R11 sync strobe");
    @(negedge clk);
    chk({31'd0, sync_stb}, 32'd0, "R11 sync strobe one cycle");

    wr_reg(1, 32'd0);
    chk({31'd0, enable}, 32'd0, "R5 disable");
    chk({31'd0, cfg_done}, 32'd0, "R5 disable clears config_done");

    wr_reg(27, 32'd1);
    chk({31'd0, cur_on}, 32'd1, "R7 show");
    wr_reg(27, 32'd2);
    chk({31'd0, cur_on}, 32'd1, "R7 code 2 holds");
    wr_reg(27, 32'd0);
    chk({31'd0, cur_on}, 32'd0, "R7 hide");
    wr_reg(27, 32'd3);
    chk({31'd0, cur_on}, 32'd0, "R7 code 3 holds");

    wr_reg(1792, 32'hcafe_0001);
    wr_reg(1807, 32'hcafe_000f);
    wr_reg(1808, 32'hbad0_0000);
    wr_reg(1791, 32'hbad0_0001);
    rd_reg(1792, 32'hcafe_0001, "R8 scratch first");
    rd_reg(1807, 32'hcafe_000f, "R8 scratch last");
    rd_reg(1808, 32'd0, "R8 beyond bank reads 0");
    rd_reg(29, 32'd16, "R8 scratch count");

    rd_reg(8, 32'd0, "R10 unknown read");
    wr_reg(8, 32'hffff_ffff);
    rd_reg(8, 32'd0, "R10 unknown write dropped");
    rd_reg(1791, 32'd0, "R10 below bank reads 0");
    rd_reg(1792, 32'hcafe_0001, "R10 bank untouched");

    wr_reg(25, 32'd11);
    bus_cycle(1'b1, 1'b0, 1'b0, 32'd25);
    e.exp = 32'd11; e.tag = "R12 same-cycle read sees old";
    sb_q.push_back(e);
    bus_cycle(1'b1, 1'b1, 1'b1, 32'd22);
    rd_reg(25, 32'd22, "R12 new value after");

    bus_cycle(1'b1, 1'b0, 1'b0, 32'd1800);
    e.exp = 32'd1800; e.tag = "R13 index readback";
    sb_q.push_back(e);
    bus_cycle(1'b0, 1'b1, 1'b0, 32'd0);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) chk(32'(sb_q.size()), 32'd0, "R13 missing read data");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule